// File: doc/BRIEF.md
# Board Power and Feature Control Register

This block is an 8-bit control register that a CPU reaches over a simple bus. It has a chip select, a write strobe, a read strobe and 8-bit write and read data. Each stored bit drives one enable line of the board. Three lines switch power to peripheral rails. One line enables the 5V switching regulator. Three lines set how the expansion bus and one serial port behave. The last bit is a scratch flag that watchdog software uses to record why the board restarted. The block drives the enable lines only. The power switches, the bus timing and the serial multiplexer that act on them lie outside it.

The bits do not all reset the same way. A power-on reset clears everything. A warm (system) reset clears the feature bits but leaves the scratch flag as it was. This lets software, after a restart, read the scratch flag and tell a watchdog expiry (flag 1) from a normal reboot or a power-up (flag 0).

The regulator-enable bit also depends on a jumper. The jumper input is sampled during power-on reset and that sample is kept until the next power-on reset. If the jumper was absent at that point, the bit defaults to 1 and software may write it. If the jumper was fitted, the bit is locked at 0.

Top module: `brd_pwr_ctrl`

## Requirements
- R1: Bits 0, 1 and 2 of the register drive `rs232_pwr_en`, `usb_pwr_en` and `lcd_pwr_en`, where 1 means the rail is on. A write with `cs` and `we` high stores `wdata` at the next rising clock edge.
- R2: Bit 4 drives `xbus_clk_off`, where 1 stops the expansion-bus clock. Bit 5 drives `xbus_fast_strobe`, where 1 selects fast non-standard strobes. Bit 6 drives `uart3_ttl_sel`, where 1 routes the third serial port to TTL header pins.
- R3: If `jumper_in` is 0 while power-on reset is applied, bit 3 (`sw5v_en`) is 1 after that reset and can then be written to 0 or 1.
- R4: If `jumper_in` is 1 while power-on reset is applied, bit 3 stays 0 on `sw5v_en` and on read-back, and writes to it have no effect.
- R5: The jumper is sampled only while `por_n` is low. A change of `jumper_in` after that reset does not change whether bit 3 is writable or locked.
- R6: While `sys_rst_n` is low, bits 0, 1, 2, 4, 5 and 6 clear to 0 and bit 3 returns to its power-on default (1 if unlocked, 0 if locked). Bus writes made during the warm reset are ignored.
- R7: Bit 7 (`scratch_flag`) is read/write. It keeps its value through a warm reset and clears only on power-on reset. After a power-on reset the whole register reads 0x08 with the jumper absent, or 0x00 with it fitted.
- R8: `rdata` shows the stored 8 bits, in the same bit positions as written, while `cs` and `re` are both high. Otherwise `rdata` is 0x00.
- R9: A cycle with `we` high but `cs` low, or with `cs` high but `we` low, leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all bits and samples the jumper |
| sys_rst_n | input | 1 | Warm reset, active low, synchronous; spares the scratch bit |
| jumper_in | input | 1 | Regulator jumper sense, 1 = fitted |
| cs | input | 1 | Register select |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not selected for read |
| rs232_pwr_en | output | 1 | RS232 level converter power enable |
| usb_pwr_en | output | 1 | USB 5V power enable |
| lcd_pwr_en | output | 1 | LCD header 5V power enable |
| sw5v_en | output | 1 | 5V switching regulator enable |
| xbus_clk_off | output | 1 | Expansion-bus clock disable |
| xbus_fast_strobe | output | 1 | Expansion-bus fast strobe select |
| uart3_ttl_sel | output | 1 | Third serial port routed to TTL pins |
| scratch_flag | output | 1 | Scratch bit kept across warm reset |

## Verification
A wrong reset class shows up on the first read after a warm reset. A warm reset that clears the scratch bit reads 0x08 where 0x88 is due, and one that spares a feature bit reads that bit as 1. A jumper sample that is kept wrong, or taken at the wrong time, flips the lock. That appears one clock after the next write to bit 3, as a 1 on `sw5v_en` while locked or a 0 that refuses to become 1 while unlocked. A broken write or select path shows up on the same combinational read that follows the write edge.

// File: rtl/brd_pwr_ctrl_pkg.sv
package brd_pwr_ctrl_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned B_RS232   = 0;
  localparam int unsigned B_USB     = 1;
  localparam int unsigned B_LCD     = 2;
  localparam int unsigned B_SW5V    = 3;
  localparam int unsigned B_CLKOFF  = 4;
  localparam int unsigned B_FASTSTB = 5;
  localparam int unsigned B_TTL     = 6;
  localparam int unsigned B_SCRATCH = 7;

  typedef logic [REG_W-1:0] ctrl_t;

  // Bit kept across warm reset
  function automatic bit spared_by_warm(input int unsigned idx);
    return idx == B_SCRATCH;
  endfunction

  // Bit whose writability and default come from the jumper
  function automatic bit jumper_bound(input int unsigned idx);
    return idx == B_SCRATCH ? 1'b0 : (idx == B_SW5V);
  endfunction

  // Value a bit takes on any reset, given jumper fitted (1) or absent (0)
  function automatic logic reset_value(input int unsigned idx, input logic fitted);
    return jumper_bound(idx) ? ~fitted : 1'b0;
  endfunction

  // Read view: locked regulator bit always reads 0
  function automatic ctrl_t read_view(input ctrl_t stored, input logic locked);
    ctrl_t v;
    v = stored;
    if (locked) v[B_SW5V] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/brd_pwr_ctrl_jumper.sv
module brd_pwr_ctrl_jumper (
  input  logic clk,
  input  logic por_n,
  input  logic jumper_in,
  output logic locked
);
  // Follows the jumper only while power-on reset is held
  logic sample_now;
  assign sample_now = ~por_n;

  always_ff @(posedge clk) begin
    if (sample_now) locked <= jumper_in;
  end

  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    por_n |=> $stable(locked)); // R5
endmodule

// File: rtl/brd_pwr_ctrl_cell.sv
module brd_pwr_ctrl_cell #(
  parameter bit SPARED = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst_n,
  input  logic rst_val,
  input  logic lock,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic q
);
  logic warm_evt;
  logic write_evt;
  assign warm_evt  = ~sys_rst_n;
  assign write_evt = wr_hit & sys_rst_n & ~lock;

  always_ff @(posedge clk) begin
    if (!por_n)           q <= rst_val;
    else if (lock)        q <= 1'b0;
    else if (warm_evt) begin
      if (!SPARED)        q <= rst_val;
    end
    else if (write_evt)   q <= wr_bit;
  end

  generate
    if (SPARED) begin : g_spared
      AST_SCRATCH_KEPT: assert property (@(posedge clk) disable iff (!por_n)
        warm_evt |=> $stable(q)); // R7
    end else begin : g_plain
      AST_WARM_RESTORE: assert property (@(posedge clk) disable iff (!por_n)
        warm_evt |=> (q == $past(rst_val))); // R6
    end
  endgenerate
endmodule

// File: rtl/brd_pwr_ctrl.sv
module brd_pwr_ctrl
  import brd_pwr_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst_n,
  input  logic       jumper_in,
  input  logic       cs,
  input  logic       we,
  input  logic       re,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rs232_pwr_en,
  output logic       usb_pwr_en,
  output logic       lcd_pwr_en,
  output logic       sw5v_en,
  output logic       xbus_clk_off,
  output logic       xbus_fast_strobe,
  output logic       uart3_ttl_sel,
  output logic       scratch_flag
);
  logic  jmp_locked;
  logic  fitted_now;
  logic  wr_hit;
  logic  rd_hit;
  ctrl_t ctrl;

  assign wr_hit = cs & we;
  assign rd_hit = cs & re;
  // during power-on reset the live pin decides; afterwards the stored sample
  assign fitted_now = por_n ? jmp_locked : jumper_in;

  brd_pwr_ctrl_jumper u_jmp (
    .clk       (clk),
    .por_n     (por_n),
    .jumper_in (jumper_in),
    .locked    (jmp_locked)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    logic cell_lock;
    if (jumper_bound(i)) begin : g_jb
      assign cell_lock = jmp_locked;
    end else begin : g_free
      assign cell_lock = 1'b0;
    end
    brd_pwr_ctrl_cell #(.SPARED(spared_by_warm(i))) u_cell (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .rst_val   (reset_value(i, fitted_now)),
      .lock      (cell_lock),
      .wr_hit    (wr_hit),
      .wr_bit    (wdata[i]),
      .q         (ctrl[i])
    );
  end

  assign rdata = rd_hit ? read_view(ctrl, jmp_locked) : '0;

  assign rs232_pwr_en     = ctrl[B_RS232];
  assign usb_pwr_en       = ctrl[B_USB];
  assign lcd_pwr_en       = ctrl[B_LCD];
  assign sw5v_en          = ctrl[B_SW5V] & ~jmp_locked;
  assign xbus_clk_off     = ctrl[B_CLKOFF];
  assign xbus_fast_strobe = ctrl[B_FASTSTB];
  assign uart3_ttl_sel    = ctrl[B_TTL];
  assign scratch_flag     = ctrl[B_SCRATCH];

  AST_LOCKED_OFF: assert property (@(posedge clk) disable iff (!por_n)
    jmp_locked |=> !ctrl[B_SW5V]); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (wr_hit && sys_rst_n) |=> ({rs232_pwr_en, usb_pwr_en, lcd_pwr_en} ==
                               {$past(wdata[0]), $past(wdata[1]), $past(wdata[2])})); // R1
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (!wr_hit && sys_rst_n) |=> $stable(ctrl)); // R9
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!por_n)
    !rd_hit |-> (rdata == 8'h00)); // R8
endmodule

// File: tb/tb_brd_pwr_ctrl.sv
module tb_brd_pwr_ctrl;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b1, jumper_in = 1'b0;
  logic cs = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic rs232_pwr_en, usb_pwr_en, lcd_pwr_en, sw5v_en;
  logic xbus_clk_off, xbus_fast_strobe, uart3_ttl_sel, scratch_flag;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  brd_pwr_ctrl dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .jumper_in(jumper_in),
    .cs(cs), .we(we), .re(re), .wdata(wdata), .rdata(rdata),
    .rs232_pwr_en(rs232_pwr_en), .usb_pwr_en(usb_pwr_en), .lcd_pwr_en(lcd_pwr_en),
    .sw5v_en(sw5v_en), .xbus_clk_off(xbus_clk_off), .xbus_fast_strobe(xbus_fast_strobe),
    .uart3_ttl_sel(uart3_ttl_sel), .scratch_flag(scratch_flag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] d, input logic c, input logic w);
    @(negedge clk); cs = c; we = w; wdata = d;
    @(negedge clk); cs = 0; we = 0; wdata = 8'h00;
  endtask

  task automatic read_check(input string req, input logic [7:0] exp);
    @(negedge clk); cs = 1; re = 1; #1;
    check(req, rdata, exp);
    cs = 0; re = 0;
  endtask

  task automatic outs_check(input string req, input logic [7:0] exp);
    @(negedge clk);
    check(req, {scratch_flag, uart3_ttl_sel, xbus_fast_strobe, xbus_clk_off,
                sw5v_en, lcd_pwr_en, usb_pwr_en, rs232_pwr_en}, exp);
  endtask

  task automatic power_on(input logic jmp);
    @(negedge clk); por_n = 0; jumper_in = jmp;
    repeat (2) @(negedge clk);
    por_n = 1;
  endtask

  task automatic warm_reset(input logic [7:0] wr_during);
    @(negedge clk); sys_rst_n = 0; cs = 1; we = 1; wdata = wr_during;
    repeat (2) @(negedge clk);
    sys_rst_n = 1; cs = 0; we = 0; wdata = 8'h00;
  endtask

  task automatic t_unlocked_basic();
    power_on(1'b0);
    read_check("R7 por default unlocked", 8'h08);
    read_check("R3 sw5v default on", 8'h08);
    bus_write(8'hFF, 1, 1);
    read_check("R1 write all ones", 8'hFF);
    outs_check("R2 outputs all on", 8'hFF);
    bus_write(8'h35, 1, 1);
    outs_check("R1 R2 pattern 35", 8'h35);
    read_check("R3 sw5v written zero", 8'h35);
    bus_write(8'hCA, 1, 1);
    read_check("R2 pattern CA", 8'hCA);
  endtask

  task automatic t_warm();
    bus_write(8'hFF, 1, 1);
    warm_reset(8'h00);
    read_check("R6 R7 warm keeps scratch", 8'h88);
    bus_write(8'h00, 1, 1);
    warm_reset(8'hF7);
    read_check("R6 warm restores sw5v, ignores write", 8'h08);
    outs_check("R7 scratch clear after warm", 8'h08);
  endtask

  task automatic t_select();
    bus_write(8'h5A, 1, 1);
    bus_write(8'hA5, 0, 1);
    read_check("R9 no cs write", 8'h5A);
    bus_write(8'hA5, 1, 0);
    read_check("R9 no we write", 8'h5A);
    @(negedge clk); cs = 1; re = 0; #1;
    check("R8 no re reads zero", rdata, 8'h00);
    cs = 0; re = 1; #1;
    check("R8 no cs reads zero", rdata, 8'h00);
    re = 0;
  endtask

  task automatic t_jumper_late_unlocked();
    bus_write(8'h80, 1, 1);
    power_on(1'b0);
    read_check("R7 por clears scratch", 8'h08);
    jumper_in = 1;
    bus_write(8'h00, 1, 1);
    read_check("R5 late fit, still writable 0", 8'h00);
    bus_write(8'h08, 1, 1);
    read_check("R5 late fit, still writable 1", 8'h08);
  endtask

  task automatic t_locked();
    power_on(1'b1);
    read_check("R4 R7 por default locked", 8'h00);
    bus_write(8'hFF, 1, 1);
    read_check("R4 write ignored on bit3", 8'hF7);
    outs_check("R4 sw5v stays off", 8'hF7);
    jumper_in = 0;
    bus_write(8'h08, 1, 1);
    read_check("R5 late removal, still locked", 8'h00);
    bus_write(8'h80, 1, 1);
    warm_reset(8'h00);
    read_check("R4 R6 warm while locked", 8'h80);
  endtask

  initial begin
    t_unlocked_basic();
    t_warm();
    t_select();
    t_jumper_late_unlocked();
    t_locked();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule